// File: doc/BRIEF.md
# Global-History Target-Buffer Branch Predictor

This fetch-stage predictor answers a lookup with a direction and a target for one instruction address and a branch kind. It keeps a history of recent branch directions, a direct-mapped target buffer whose index is the word address of the instruction XORed with that history, and a return stack that supplies targets for return-type branches. The answer is registered, so it appears on the cycle after the request.

History and return stack each exist twice. A speculative copy advances on every lookup, using the predicted direction and the lookup's call or return kind. A committed copy advances on every resolved update. The target buffer is trained only by updates. A flush throws away all speculative progress by copying the committed history and committed stack into the speculative ones. If an update arrives in the same cycle, the copy includes that update.

Counters reset to the weak state on the side chosen by a static-policy input, which is sampled while reset is held. Instructions are four bytes long, so the fall-through address is the instruction address plus 4. Address bits [1:0] never take part in indexing.

Top module: `gshare_predictor`

## Requirements
- R1: `rsp_vld` is high in exactly the cycles that follow a cycle with `pred_req` high, and low during and right after reset.
- R2: The lookup index is `pred_pc[IDX_W+1:2]` XOR the speculative history. The update index is `upd_pc[IDX_W+1:2]` XOR the committed history.
- R3: Each history shifts left by one bit, takes the new direction into bit 0 and keeps the oldest outcome in the MSB. The speculative history shifts on every lookup using the predicted direction. The committed history shifts on every update using the resolved direction. Both reset to zero.
- R4: An update increments its entry's counter when taken and decrements it when not taken, saturating at 0 and 2^CTR_W-1. A taken update also overwrites the entry's target with `upd_tgt`. Counter MSB set means predict taken.
- R5: During reset every counter becomes 2^(CTR_W-1) when `static_taken` is 1, and 2^(CTR_W-1)-1 when it is 0. Every target becomes zero.
- R6: Kind code 4 (unconditional) and kind code 3 (call) are always predicted taken. Their target is `pred_tgt` when `pred_tgt_vld` is 1, else the entry target.
- R7: Kind codes 0 (conditional) and 1 (loop-closing), and the unused codes 5 to 7, follow the counter MSB. When predicted taken the target is chosen as in R6. When predicted not taken the target is `pred_pc+4`.
- R8: A call pushes `pc+4` onto the stack it belongs to: a lookup pushes onto the speculative stack, an update onto the committed stack.
- R9: Kind code 2 (return) is always predicted taken, with the popped speculative top as its target. When the stack is empty the target is `pred_pc+4` and the stack is left unchanged. A return update pops the committed stack.
- R10: A push onto a full stack of RAS_DEPTH entries overwrites the oldest entry and keeps the count at RAS_DEPTH.
- R11: A flush sets the speculative history and speculative stack equal to the committed ones, including any update in the same cycle. Any lookup in that cycle still gets its answer but has no effect on the speculative state.
- R12: A lookup and an update in the same cycle: the lookup reads the buffer contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| static_taken | input | 1 | Static policy applied to the counters during reset |
| pred_req | input | 1 | Lookup request |
| pred_pc | input | ADDR_W | Lookup instruction address |
| pred_type | input | 3 | Lookup branch kind code |
| pred_tgt_vld | input | 1 | Known target supplied |
| pred_tgt | input | ADDR_W | Known target |
| upd_vld | input | 1 | Resolved-branch update |
| upd_pc | input | ADDR_W | Update instruction address |
| upd_type | input | 3 | Update branch kind code |
| upd_taken | input | 1 | Resolved direction |
| upd_tgt | input | ADDR_W | Resolved target |
| flush | input | 1 | Restore speculative state from committed state |
| rsp_vld | output | 1 | Registered answer valid |
| rsp_taken | output | 1 | Predicted direction |
| rsp_target | output | ADDR_W | Predicted target |

## Verification
A lookup and an update can land in the same cycle. When they hit the same entry, the answer must show the counter and target from before the update. The bench triggers this on purpose by sending an update and a lookup with matching addresses together, and the random phase also overlaps them often. A flush can also coincide with a call update. The return lookup that follows must then see that call's return address on the restored stack. Every answer is compared with a bench model that applies the lookup side against the pre-update state and then applies the update and the flush in that order.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [2:0] {
        BK_COND = 3'd0,
        BK_LOOP = 3'd1,
        BK_RET  = 3'd2,
        BK_CALL = 3'd3,
        BK_JUMP = 3'd4
    } br_kind_e;

    typedef enum logic {
        RSP_IDLE  = 1'b0,
        RSP_VALID = 1'b1
    } rsp_state_e;

    // Unused codes fall back to the conditional behaviour.
    function automatic br_kind_e kind_of(input logic [2:0] code);
        br_kind_e k;
        case (code)
            3'd1:    k = BK_LOOP;
            3'd2:    k = BK_RET;
            3'd3:    k = BK_CALL;
            3'd4:    k = BK_JUMP;
            default: k = BK_COND;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/bp_history.sv
module bp_history #(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_shift,
    input  logic              spec_bit,
    input  logic              com_shift,
    input  logic              com_bit,
    input  logic              restore,
    output logic [HIST_W-1:0] spec_hist,
    output logic [HIST_W-1:0] com_hist
);
    logic [HIST_W-1:0] com_nxt, spec_nxt;

    always_comb begin
        com_nxt = com_hist;
        if (com_shift) com_nxt = {com_hist[HIST_W-2:0], com_bit};
    end

    always_comb begin
        spec_nxt = spec_hist;
        if (restore)         spec_nxt = com_nxt;
        else if (spec_shift) spec_nxt = {spec_hist[HIST_W-2:0], spec_bit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_hist <= '0;
            com_hist  <= '0;
        end else begin
            spec_hist <= spec_nxt;
            com_hist  <= com_nxt;
        end
    end

    // R3
    com_hist_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        com_shift |=> com_hist[0] == $past(com_bit));

    // R11
    restore_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> spec_hist == com_hist);

endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
    parameter int IDX_W  = 6,
    parameter int CTR_W  = 2,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              static_taken,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CTR_W-1:0]  rd_ctr,
    output logic [ADDR_W-1:0] rd_tgt,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken,
    input  logic [ADDR_W-1:0] wr_tgt
);
    localparam int               ENTRIES = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX = '1;
    localparam logic [CTR_W-1:0] WEAK_T  = CTR_W'(1) << (CTR_W - 1);
    localparam logic [CTR_W-1:0] WEAK_N  = WEAK_T - CTR_W'(1);

    logic [CTR_W-1:0]  ctr_mem [ENTRIES];
    logic [ADDR_W-1:0] tgt_mem [ENTRIES];
    logic [CTR_W-1:0]  ctr_new;

    assign rd_ctr = ctr_mem[rd_idx];
    assign rd_tgt = tgt_mem[rd_idx];

    always_comb begin
        ctr_new = ctr_mem[wr_idx];
        if (wr_taken && ctr_mem[wr_idx] != CTR_MAX)      ctr_new = ctr_mem[wr_idx] + CTR_W'(1);
        else if (!wr_taken && ctr_mem[wr_idx] != '0)     ctr_new = ctr_mem[wr_idx] - CTR_W'(1);
    end

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctr_mem[e] <= static_taken ? WEAK_T : WEAK_N;
                    tgt_mem[e] <= '0;
                end else if (wr_en && wr_idx == IDX_W'(e)) begin
                    ctr_mem[e] <= ctr_new;
                    if (wr_taken) tgt_mem[e] <= wr_tgt;
                end
            end
        end
    endgenerate

    // R4
    ctr_top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken && ctr_mem[wr_idx] == CTR_MAX |=> ctr_mem[$past(wr_idx)] == CTR_MAX);

    // R4
    ctr_low_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken && ctr_mem[wr_idx] == '0 |=> ctr_mem[$past(wr_idx)] == '0);

    // R4
    tgt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken |=> tgt_mem[$past(wr_idx)] == $past(wr_tgt));

endmodule

// File: rtl/bp_ret_stacks.sv
module bp_ret_stacks #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_push,
    input  logic              spec_pop,
    input  logic [ADDR_W-1:0] spec_val,
    input  logic              com_push,
    input  logic              com_pop,
    input  logic [ADDR_W-1:0] com_val,
    input  logic              restore,
    output logic [ADDR_W-1:0] spec_top_val,
    output logic              spec_empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] s_mem [DEPTH];
    logic [ADDR_W-1:0] c_mem [DEPTH];
    logic [ADDR_W-1:0] s_mem_n [DEPTH];
    logic [ADDR_W-1:0] c_mem_n [DEPTH];
    logic [PTR_W-1:0]  s_top, c_top, s_top_n, c_top_n;
    logic [CNT_W-1:0]  s_cnt, c_cnt, s_cnt_n, c_cnt_n;

    assign spec_top_val = s_mem[s_top];
    assign spec_empty   = (s_cnt == '0);

    always_comb begin
        c_mem_n = c_mem;
        c_top_n = c_top;
        c_cnt_n = c_cnt;
        if (com_push) begin
            c_top_n          = c_top + PTR_W'(1);
            c_mem_n[c_top_n] = com_val;
            if (c_cnt != FULL) c_cnt_n = c_cnt + CNT_W'(1);
        end else if (com_pop && c_cnt != '0) begin
            c_top_n = c_top - PTR_W'(1);
            c_cnt_n = c_cnt - CNT_W'(1);
        end
    end

    always_comb begin
        s_mem_n = s_mem;
        s_top_n = s_top;
        s_cnt_n = s_cnt;
        if (restore) begin
            s_mem_n = c_mem_n;
            s_top_n = c_top_n;
            s_cnt_n = c_cnt_n;
        end else if (spec_push) begin
            s_top_n          = s_top + PTR_W'(1);
            s_mem_n[s_top_n] = spec_val;
            if (s_cnt != FULL) s_cnt_n = s_cnt + CNT_W'(1);
        end else if (spec_pop && s_cnt != '0) begin
            s_top_n = s_top - PTR_W'(1);
            s_cnt_n = s_cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                s_mem[i] <= '0;
                c_mem[i] <= '0;
            end
            s_top <= '0;
            c_top <= '0;
            s_cnt <= '0;
            c_cnt <= '0;
        end else begin
            s_mem <= s_mem_n;
            c_mem <= c_mem_n;
            s_top <= s_top_n;
            c_top <= c_top_n;
            s_cnt <= s_cnt_n;
            c_cnt <= c_cnt_n;
        end
    end

    // R10
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restore && spec_push && s_cnt == FULL |=> s_cnt == FULL);

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restore && spec_pop && s_cnt == '0 |=> s_cnt == '0 && $stable(s_top));

    // R11
    stack_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> s_cnt == c_cnt && s_top == c_top);

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
    import bp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 6,
    parameter int CTR_W     = 2,
    parameter int RAS_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              static_taken,
    input  logic              pred_req,
    input  logic [ADDR_W-1:0] pred_pc,
    input  logic [2:0]        pred_type,
    input  logic              pred_tgt_vld,
    input  logic [ADDR_W-1:0] pred_tgt,
    input  logic              upd_vld,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [2:0]        upd_type,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_tgt,
    input  logic              flush,
    output logic              rsp_vld,
    output logic              rsp_taken,
    output logic [ADDR_W-1:0] rsp_target
);
    localparam int HIST_W = IDX_W;
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    br_kind_e          p_kind, u_kind;
    rsp_state_e        state_q, state_d;
    logic [HIST_W-1:0] spec_hist, com_hist;
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [CTR_W-1:0]  rd_ctr;
    logic [ADDR_W-1:0] rd_tgt, known_tgt, seq_pc, upd_seq_pc;
    logic [ADDR_W-1:0] ras_top;
    logic              ras_empty;
    logic              p_taken;
    logic [ADDR_W-1:0] p_target;

    assign p_kind     = kind_of(pred_type);
    assign u_kind     = kind_of(upd_type);
    assign rd_idx     = pred_pc[IDX_W+1:2] ^ spec_hist;
    assign wr_idx     = upd_pc[IDX_W+1:2] ^ com_hist;
    assign seq_pc     = pred_pc + INSN_BYTES;
    assign upd_seq_pc = upd_pc + INSN_BYTES;
    assign known_tgt  = pred_tgt_vld ? pred_tgt : rd_tgt;

    bp_history #(.HIST_W(HIST_W)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .spec_shift (pred_req),
        .spec_bit   (p_taken),
        .com_shift  (upd_vld),
        .com_bit    (upd_taken),
        .restore    (flush),
        .spec_hist  (spec_hist),
        .com_hist   (com_hist)
    );

    bp_target_buf #(.IDX_W(IDX_W), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .static_taken (static_taken),
        .rd_idx       (rd_idx),
        .rd_ctr       (rd_ctr),
        .rd_tgt       (rd_tgt),
        .wr_en        (upd_vld),
        .wr_idx       (wr_idx),
        .wr_taken     (upd_taken),
        .wr_tgt       (upd_tgt)
    );

    bp_ret_stacks #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk          (clk),
        .rst_n        (rst_n),
        .spec_push    (pred_req && p_kind == BK_CALL),
        .spec_pop     (pred_req && p_kind == BK_RET),
        .spec_val     (seq_pc),
        .com_push     (upd_vld && u_kind == BK_CALL),
        .com_pop      (upd_vld && u_kind == BK_RET),
        .com_val      (upd_seq_pc),
        .restore      (flush),
        .spec_top_val (ras_top),
        .spec_empty   (ras_empty)
    );

    // Direction and target selection by branch kind.
    always_comb begin
        p_taken  = 1'b1;
        p_target = known_tgt;
        unique case (p_kind)
            BK_COND, BK_LOOP: begin
                p_taken  = rd_ctr[CTR_W-1];
                p_target = rd_ctr[CTR_W-1] ? known_tgt : seq_pc;
            end
            BK_RET: begin
                p_taken  = 1'b1;
                p_target = ras_empty ? seq_pc : ras_top;
            end
            BK_CALL, BK_JUMP: begin
                p_taken  = 1'b1;
                p_target = known_tgt;
            end
            default: begin
                p_taken  = 1'b1;
                p_target = known_tgt;
            end
        endcase
    end

    // Response state: RSP_IDLE -> RSP_VALID on a request, RSP_VALID -> RSP_IDLE without one.
    always_comb begin
        unique case (state_q)
            RSP_IDLE:  state_d = pred_req ? RSP_VALID : RSP_IDLE;
            RSP_VALID: state_d = pred_req ? RSP_VALID : RSP_IDLE;
            default:   state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_taken  <= 1'b0;
            rsp_target <= '0;
        end else if (pred_req) begin
            rsp_taken  <= p_taken;
            rsp_target <= p_target;
        end
    end

    assign rsp_vld = (state_q == RSP_VALID);

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req |=> rsp_vld);

    // R1
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_req |=> !rsp_vld);

    // R6
    jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req && pred_type == 3'd4 |=> rsp_taken);

    // R7
    fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req |=> rsp_taken || rsp_target == $past(pred_pc) + INSN_BYTES);

endmodule

// File: tb/gshare_predictor_test.sv
module gshare_predictor_test;
    localparam int CLK_PERIOD = 10;
    localparam int IDX = 6;
    localparam int ENT = 1 << IDX;
    localparam int DEP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        static_taken = 1'b1;
    logic        pred_req = 1'b0, pred_tgt_vld = 1'b0, upd_vld = 1'b0, upd_taken = 1'b0, flush = 1'b0;
    logic [31:0] pred_pc = '0, pred_tgt = '0, upd_pc = '0, upd_tgt = '0;
    logic [2:0]  pred_type = '0, upd_type = '0;
    logic        rsp_vld, rsp_taken;
    logic [31:0] rsp_target;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [1:0]     m_ctr [ENT];
    logic [31:0]    m_tgt [ENT];
    logic [IDX-1:0] m_sh, m_ch;
    logic [31:0]    m_rs [2][DEP];
    int             m_top [2];
    int             m_cnt [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    gshare_predictor uut (
        .clk(clk), .rst_n(rst_n), .static_taken(static_taken),
        .pred_req(pred_req), .pred_pc(pred_pc), .pred_type(pred_type),
        .pred_tgt_vld(pred_tgt_vld), .pred_tgt(pred_tgt),
        .upd_vld(upd_vld), .upd_pc(upd_pc), .upd_type(upd_type),
        .upd_taken(upd_taken), .upd_tgt(upd_tgt), .flush(flush),
        .rsp_vld(rsp_vld), .rsp_taken(rsp_taken), .rsp_target(rsp_target)
    );

    function automatic int kind(input logic [2:0] c);
        return (c > 3'd4) ? 0 : int'(c);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic m_push(input int s, input logic [31:0] v);
        m_top[s] = (m_top[s] + 1) % DEP;
        m_rs[s][m_top[s]] = v;
        if (m_cnt[s] < DEP) m_cnt[s]++;
    endtask

    task automatic m_pop(input int s);
        if (m_cnt[s] > 0) begin
            m_top[s] = (m_top[s] + DEP - 1) % DEP;
            m_cnt[s]--;
        end
    endtask

    task automatic do_reset(input logic st);
        @(negedge clk);
        rst_n = 1'b0; static_taken = st;
        pred_req = 0; upd_vld = 0; flush = 0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < ENT; i++) begin
            m_ctr[i] = st ? 2'd2 : 2'd1;
            m_tgt[i] = '0;
        end
        m_sh = '0; m_ch = '0;
        for (int s = 0; s < 2; s++) begin
            m_top[s] = 0; m_cnt[s] = 0;
            for (int i = 0; i < DEP; i++) m_rs[s][i] = '0;
        end
        chk("R1 reset rsp_vld", {31'd0, rsp_vld}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post-reset rsp_vld", {31'd0, rsp_vld}, 32'd0);
    endtask

    // One cycle: drive at negedge, model, check at the following negedge.
    task automatic do_cycle(input string tag, input bit rq, input logic [31:0] pc, input logic [2:0] ty,
                            input bit kv, input logic [31:0] kt, input bit uv, input logic [31:0] upc,
                            input logic [2:0] uty, input bit ut, input logic [31:0] utg, input bit fl);
        logic [IDX-1:0] idx, ui;
        logic [31:0] seq, kn, etg;
        logic et;
        pred_req = rq; pred_pc = pc; pred_type = ty; pred_tgt_vld = kv; pred_tgt = kt;
        upd_vld = uv; upd_pc = upd_pc; upd_pc = upc; upd_type = uty; upd_taken = ut; upd_tgt = utg;
        flush = fl;
        idx = pc[IDX+1:2] ^ m_sh;
        seq = pc + 32'd4;
        kn  = kv ? kt : m_tgt[idx];
        case (kind(ty))
            0, 1: begin et = m_ctr[idx][1]; etg = et ? kn : seq; end
            2: begin et = 1'b1; etg = (m_cnt[0] == 0) ? seq : m_rs[0][m_top[0]]; end
            default: begin et = 1'b1; etg = kn; end
        endcase
        if (uv) begin
            ui = upc[IDX+1:2] ^ m_ch;
            if (ut && m_ctr[ui] != 2'd3) m_ctr[ui]++;
            if (!ut && m_ctr[ui] != 2'd0) m_ctr[ui]--;
            if (ut) m_tgt[ui] = utg;
            m_ch = {m_ch[IDX-2:0], ut};
            if (kind(uty) == 3) m_push(1, upc + 32'd4);
            if (kind(uty) == 2) m_pop(1);
        end
        if (fl) begin
            m_sh = m_ch; m_rs[0] = m_rs[1]; m_top[0] = m_top[1]; m_cnt[0] = m_cnt[1];
        end else if (rq) begin
            m_sh = {m_sh[IDX-2:0], et};
            if (kind(ty) == 3) m_push(0, seq);
            if (kind(ty) == 2) m_pop(0);
        end
        @(posedge clk);
        @(negedge clk);
        pred_req = 0; upd_vld = 0; flush = 0;
        chk({tag, " R1 vld"}, {31'd0, rsp_vld}, {31'd0, rq});
        if (rq) begin
            chk({tag, " taken"}, {31'd0, rsp_taken}, {31'd0, et});
            chk({tag, " target"}, rsp_target, etg);
        end
    endtask

    task automatic pred(input string tag, input logic [31:0] pc, input logic [2:0] ty);
        do_cycle(tag, 1, pc, ty, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic upd(input string tag, input logic [31:0] pc, input logic [2:0] ty, input bit t,
                       input logic [31:0] tg);
        do_cycle(tag, 0, 0, 0, 0, 0, 1, pc, ty, t, tg, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset(1'b1);
        pred("R5 weak-taken seed", 32'h100, 3'd0);
        do_cycle("R6 jump known tgt", 1, 32'h140, 3'd4, 1, 32'h2000, 0, 0, 0, 0, 0, 0);
        pred("R9 return on empty", 32'h180, 3'd2);
        pred("R8 call push", 32'h200, 3'd3);
        pred("R9 return pops call", 32'h800, 3'd2);
        for (int i = 0; i < 5; i++) pred("R10 fill", 32'h300 + 32'(i * 16), 3'd3);
        for (int i = 0; i < 5; i++) pred("R10 drain", 32'h900, 3'd2);
        do_cycle("R11 flush", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 4; i++) upd("R4 train up", 32'h440, 3'd0, 1, 32'h5550);
        do_cycle("R11 flush hist", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        pred("R2 R4 trained entry", 32'h440, 3'd1);
        do_cycle("R11 flush again", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 5; i++) upd("R4 train down", 32'h480, 3'd0, 0, 32'h0);
        do_cycle("R11 flush sync", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        pred("R7 fall-through", 32'h480, 3'd0);
        pred("R7 unused code", 32'h484, 3'd6);
        pred("R11 spec call", 32'h500, 3'd3);
        do_cycle("R11 flush drops call", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        pred("R11 return after flush", 32'h600, 3'd2);
        do_cycle("R11 flush with call update", 0, 0, 0, 0, 0, 1, 32'h700, 3'd3, 1, 32'h7700, 1);
        pred("R11 return sees update", 32'h620, 3'd2);
        do_cycle("R11 sync", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        do_cycle("R12 same cycle", 1, 32'h4c0, 3'd0, 0, 0, 1, 32'h4c0, 3'd0, 1, 32'h6600, 0);
        do_cycle("R12 same cycle again", 1, 32'h4c0, 3'd0, 0, 0, 1, 32'h4c0, 3'd0, 0, 0, 0);
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a, b;
            a = 32'h1000 + (($urandom % 48) * 4);
            b = 32'h1000 + (($urandom % 48) * 4);
            do_cycle("R2 R3 random", ($urandom % 4) != 0, a, 3'($urandom % 8), ($urandom % 3) == 0,
                     $urandom & 32'hFFFC, ($urandom % 2) == 0, b, 3'($urandom % 8), ($urandom % 2) == 0,
                     $urandom & 32'hFFFC, ($urandom % 16) == 0);
        end
        do_reset(1'b0);
        pred("R5 weak-not-taken seed", 32'h100, 3'd0);
        pred("R5 loop kind", 32'h104, 3'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule